// File: doc/BRIEF.md
# Two-Rate Three-Color Token Policer

The policer meters a stream of packets against two token buckets: a committed bucket and a peak bucket. A free-running time base produces a refill pulse at a configurable interval. On that pulse each bucket gains a fixed number of tokens, up to its own cap. Every packet offered on the valid/ready interface has a token cost, taken from its length or from a fixed per-packet adjustment. The policer marks the packet green, yellow or red according to which bucket can pay for it. A per-color action code then decides whether the packet passes or is dropped.

Tokens are kept in fixed point with 8 fractional bits, so one unit is 1/256 of a token. All rates and bucket sizes use a mantissa/exponent encoding. An exponent of 24 or more encodes zero, which turns the peak bucket off and leaves a two-outcome (green/red) meter. A packet-count mode ignores the length, so the meter limits packets per interval instead of bytes.

Top module: `trtcm_policer`

## Requirements
- R1: In reset and in the first cycle after it, each bucket level is loaded with its configured cap and `res_valid` is low.
- R2: A refill pulse occurs once every `UNIT_CYCLES`·2^`cfg_tick_div` clock cycles. `pkt_ready` is low in exactly that cycle, and no packet is accepted in that cycle.
- R3: On a refill pulse each bucket level becomes min(level + fill, cap). Fill and cap are each (256 + mantissa)·2^exponent in 1/256-token units. An exponent of 24 or more makes the value zero.
- R4: A packet's cost in 1/256-token units is max(L·256 + (`cfg_adj_man` − 256)·2^`cfg_adj_exp`, 1), saturated at 2^34 − 1. In byte mode (`cfg_pkt_mode` = 0), L = `pkt_len` − `cfg_len_off`, or 0 when `pkt_len` ≤ `cfg_len_off`.
- R5: In packet mode (`cfg_pkt_mode` = 1), L is 0 regardless of `pkt_len`. With adjust mantissa 384 and exponent 1, every packet costs exactly one token.
- R6: A packet whose starting color is green is marked green if the committed level is at least its cost. The cost is then subtracted from the committed bucket only.
- R7: Otherwise, if the starting color is not red and the peak level is at least the cost, the packet is yellow and the cost is subtracted from the peak bucket only. In every other case it is red and neither bucket changes.
- R8: When the peak bucket is configured as zero (rate and burst exponents of 24 or more), no packet is ever marked yellow.
- R9: Color mode 3 is color-blind: every packet starts as green and `pkt_color` has no effect. In any other mode, `pkt_color` sets the starting color: 0 green, 1 yellow, 2 or 3 red.
- R10: `res_drop` is 0 when the action code for the result color is 0 (pass), and 1 for any nonzero code (drop).
- R11: `res_valid` is high for one cycle, in the cycle after an accepted packet, and at no other time. `res_color` encodes green as 0, yellow as 1 and red as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_crate_man | input | 8 | Committed refill mantissa |
| cfg_crate_exp | input | 5 | Committed refill exponent |
| cfg_cburst_man | input | 8 | Committed cap mantissa |
| cfg_cburst_exp | input | 5 | Committed cap exponent |
| cfg_prate_man | input | 8 | Peak refill mantissa |
| cfg_prate_exp | input | 5 | Peak refill exponent |
| cfg_pburst_man | input | 8 | Peak cap mantissa |
| cfg_pburst_exp | input | 5 | Peak cap exponent |
| cfg_tick_div | input | 4 | Refill interval divider (power of two) |
| cfg_pkt_mode | input | 1 | 1 = cost ignores packet length |
| cfg_len_off | input | LEN_W | Length offset subtracted in byte mode |
| cfg_adj_man | input | 9 | Per-packet adjust mantissa |
| cfg_adj_exp | input | 5 | Per-packet adjust exponent |
| cfg_color_mode | input | 2 | 3 = color-blind, otherwise color-aware |
| cfg_act_green | input | 2 | Action code for green |
| cfg_act_yellow | input | 2 | Action code for yellow |
| cfg_act_red | input | 2 | Action code for red |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Packet can be accepted this cycle |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_color | input | 2 | Incoming color for color-aware mode |
| res_valid | output | 1 | Result valid |
| res_color | output | 2 | Result color |
| res_drop | output | 1 | Result action: 1 = drop |

## Verification
The assertions check several properties on every cycle:
- the time-base counter stays in range;
- a refill never leaves a bucket above its cap;
- a debit never exceeds the level it draws from, and always lowers it;
- at most one bucket pays for any packet;
- a red result leaves both levels unchanged;
- an empty peak bucket never yields yellow;
- every result traces back to an accepted packet.

The arithmetic can only be shown by the bench's scenarios, which compare each result against a bucket model kept at the ports. That arithmetic covers the refill amounts, cap clamping across several intervals, the cost formula with offset and negative adjust, the one-token packet mode, color-aware starting colors and the mapping from action codes to pass or drop.

// File: rtl/pol_pkg.sv
package pol_pkg;
    localparam int MAN_W     = 8;
    localparam int EXP_W     = 5;
    localparam int ADJ_MAN_W = 9;
    localparam int DIV_W     = 4;
    localparam int ACT_W     = 2;
    localparam int FRAC_W    = 8;
    // exponent at and above which an encoded value means zero
    localparam int EXP_ZERO  = 24;
    // largest non-zero value is (2^(MAN_W+1)-1) << (EXP_ZERO-1); two bits of headroom for sums
    localparam int TOK_W     = MAN_W + 1 + (EXP_ZERO - 1) + 2;
    localparam logic [1:0] BLIND_MODE = 2'd3;

    typedef logic [TOK_W-1:0] tok_t;

    typedef enum logic [1:0] {
        COL_GREEN  = 2'd0,
        COL_YELLOW = 2'd1,
        COL_RED    = 2'd2,
        COL_RSVD   = 2'd3
    } color_e;

    typedef struct packed {
        logic [MAN_W-1:0] man;
        logic [EXP_W-1:0] ex;
    } mx_t;

    typedef struct packed {
        color_e color;
        logic   drop;
    } verdict_t;

    // (1 + man/256) * 2^ex tokens, expressed in 1/256-token units
    function automatic tok_t mx_to_tok(mx_t v);
        tok_t base;
        if (v.ex >= EXP_W'(EXP_ZERO)) return '0;
        base = tok_t'({1'b1, v.man});
        return base << v.ex;
    endfunction

    function automatic logic act_drops(logic [ACT_W-1:0] code);
        return code != '0;
    endfunction
endpackage

// File: rtl/pol_timebase.sv
module pol_timebase
    import pol_pkg::*;
#(
    parameter int UNIT_CYCLES = 250
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int UC_W   = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
    localparam int DCNT_W = (1 << DIV_W) - 1;
    localparam logic [UC_W-1:0] UC_LAST = UC_W'(UNIT_CYCLES - 1);

    logic [UC_W-1:0]   unit_cnt;
    logic [DCNT_W-1:0] div_cnt;
    logic [DCNT_W-1:0] div_lim;
    logic              unit_end;

    always_comb begin
        unit_end = (unit_cnt == UC_LAST);
        div_lim  = ~({DCNT_W{1'b1}} << div);
        // >= keeps the interval bounded when the divider is lowered mid-count
        tick     = unit_end && (div_cnt >= div_lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unit_cnt <= '0;
            div_cnt  <= '0;
        end else begin
            unit_cnt <= unit_end ? '0 : unit_cnt + 1'b1;
            if (tick)
                div_cnt <= '0;
            else if (unit_end)
                div_cnt <= div_cnt + 1'b1;
        end
    end

    // R2
    unit_range_chk: assert property (@(posedge clk) disable iff (rst)
        unit_cnt <= UC_LAST);
endmodule

// File: rtl/pol_cost.sv
module pol_cost
    import pol_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0]     len,
    input  logic [LEN_W-1:0]     len_off,
    input  logic                 pkt_mode,
    input  logic [ADJ_MAN_W-1:0] adj_man,
    input  logic [EXP_W-1:0]     adj_exp,
    output tok_t                 cost
);
    localparam int WIDEST = (TOK_W > LEN_W + FRAC_W) ? TOK_W : LEN_W + FRAC_W;
    localparam int ACC_W  = WIDEST + 16;
    localparam logic signed [ACC_W-1:0] ONE_TOK = ACC_W'(1) << FRAC_W;
    localparam logic signed [ACC_W-1:0] MIN_C   = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] SAT_C   = $signed({{(ACC_W-TOK_W){1'b0}}, {TOK_W{1'b1}}});

    logic [LEN_W-1:0]        eff_len;
    logic signed [ACC_W-1:0] len_part;
    logic signed [ACC_W-1:0] adj_base;
    logic signed [ACC_W-1:0] adj_part;
    logic signed [ACC_W-1:0] sum;

    always_comb begin
        eff_len  = (pkt_mode || (len <= len_off)) ? '0 : len - len_off;
        len_part = $signed({{(ACC_W-LEN_W-FRAC_W){1'b0}}, eff_len, {FRAC_W{1'b0}}});
        adj_base = $signed({{(ACC_W-ADJ_MAN_W){1'b0}}, adj_man}) - ONE_TOK;
        adj_part = adj_base <<< adj_exp;
        sum      = len_part + adj_part;
        if (sum < MIN_C)
            cost = tok_t'(1);
        else if (sum > SAT_C)
            cost = '1;
        else
            cost = sum[TOK_W-1:0];
    end
endmodule

// File: rtl/pol_bucket.sv
module pol_bucket
    import pol_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  tok_t cap,
    input  tok_t fill,
    input  logic refill,
    input  logic debit,
    input  tok_t cost,
    output tok_t lvl
);
    tok_t sum;

    always_comb sum = lvl + fill;

    always_ff @(posedge clk) begin
        if (rst)
            lvl <= cap;
        else if (refill)
            lvl <= (sum > cap) ? cap : sum;
        else if (debit)
            lvl <= lvl - cost;
    end

    // R3
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        refill |=> lvl <= $past(cap));
    // R6
    debit_cover_chk: assert property (@(posedge clk) disable iff (rst)
        debit |-> cost <= lvl);
    // R6
    debit_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (debit && !refill) |=> lvl < $past(lvl));
endmodule

// File: rtl/trtcm_policer.sv
module trtcm_policer
    import pol_pkg::*;
#(
    parameter int UNIT_CYCLES = 250,
    parameter int LEN_W       = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MAN_W-1:0]     cfg_crate_man,
    input  logic [EXP_W-1:0]     cfg_crate_exp,
    input  logic [MAN_W-1:0]     cfg_cburst_man,
    input  logic [EXP_W-1:0]     cfg_cburst_exp,
    input  logic [MAN_W-1:0]     cfg_prate_man,
    input  logic [EXP_W-1:0]     cfg_prate_exp,
    input  logic [MAN_W-1:0]     cfg_pburst_man,
    input  logic [EXP_W-1:0]     cfg_pburst_exp,
    input  logic [DIV_W-1:0]     cfg_tick_div,
    input  logic                 cfg_pkt_mode,
    input  logic [LEN_W-1:0]     cfg_len_off,
    input  logic [ADJ_MAN_W-1:0] cfg_adj_man,
    input  logic [EXP_W-1:0]     cfg_adj_exp,
    input  logic [1:0]           cfg_color_mode,
    input  logic [ACT_W-1:0]     cfg_act_green,
    input  logic [ACT_W-1:0]     cfg_act_yellow,
    input  logic [ACT_W-1:0]     cfg_act_red,
    input  logic                 pkt_valid,
    output logic                 pkt_ready,
    input  logic [LEN_W-1:0]     pkt_len,
    input  logic [1:0]           pkt_color,
    output logic                 res_valid,
    output logic [1:0]           res_color,
    output logic                 res_drop
);
    localparam int NB  = 2;
    localparam int B_C = 0;
    localparam int B_P = 1;

    tok_t           cap  [NB];
    tok_t           fill [NB];
    tok_t           lvl  [NB];
    logic [NB-1:0]  debit;
    tok_t           cost;
    logic           tick;
    logic           accept;
    logic           fits_c;
    logic           fits_p;
    color_e         in_col;
    verdict_t       verdict;
    verdict_t       res_q;

    assign cap[B_C]  = mx_to_tok(mx_t'{cfg_cburst_man, cfg_cburst_exp});
    assign fill[B_C] = mx_to_tok(mx_t'{cfg_crate_man,  cfg_crate_exp});
    assign cap[B_P]  = mx_to_tok(mx_t'{cfg_pburst_man, cfg_pburst_exp});
    assign fill[B_P] = mx_to_tok(mx_t'{cfg_prate_man,  cfg_prate_exp});

    pol_timebase #(.UNIT_CYCLES(UNIT_CYCLES)) u_tb (
        .clk  (clk),
        .rst  (rst),
        .div  (cfg_tick_div),
        .tick (tick)
    );

    pol_cost #(.LEN_W(LEN_W)) u_cost (
        .len      (pkt_len),
        .len_off  (cfg_len_off),
        .pkt_mode (cfg_pkt_mode),
        .adj_man  (cfg_adj_man),
        .adj_exp  (cfg_adj_exp),
        .cost     (cost)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bkt
        pol_bucket u_bkt (
            .clk    (clk),
            .rst    (rst),
            .cap    (cap[b]),
            .fill   (fill[b]),
            .refill (tick),
            .debit  (debit[b]),
            .cost   (cost),
            .lvl    (lvl[b])
        );
    end

    assign pkt_ready = ~tick;
    assign accept    = pkt_valid && pkt_ready;

    always_comb begin
        in_col = (cfg_color_mode == BLIND_MODE) ? COL_GREEN : color_e'(pkt_color);
        fits_c = lvl[B_C] >= cost;
        fits_p = lvl[B_P] >= cost;
        case (in_col)
            COL_GREEN:  verdict.color = fits_c ? COL_GREEN : (fits_p ? COL_YELLOW : COL_RED);
            COL_YELLOW: verdict.color = fits_p ? COL_YELLOW : COL_RED;
            default:    verdict.color = COL_RED;
        endcase
        case (verdict.color)
            COL_GREEN:  verdict.drop = act_drops(cfg_act_green);
            COL_YELLOW: verdict.drop = act_drops(cfg_act_yellow);
            default:    verdict.drop = act_drops(cfg_act_red);
        endcase
        debit[B_C] = accept && (verdict.color == COL_GREEN);
        debit[B_P] = accept && (verdict.color == COL_YELLOW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_q     <= '{color: COL_GREEN, drop: 1'b0};
        end else begin
            res_valid <= accept;
            if (accept) res_q <= verdict;
        end
    end

    assign res_color = res_q.color;
    assign res_drop  = res_q.drop;

    // R11
    res_origin_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(pkt_valid && pkt_ready));
    // R7
    red_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_color == COL_RED) |->
            (lvl[B_C] == $past(lvl[B_C]) && lvl[B_P] == $past(lvl[B_P])));
    // R7
    one_bucket_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !(lvl[B_C] < $past(lvl[B_C]) && lvl[B_P] < $past(lvl[B_P])));
    // R8
    no_yellow_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(lvl[B_P]) == '0) |-> res_color != COL_YELLOW);
endmodule

// File: tb/sim_trtcm_policer.sv
module sim_trtcm_policer;
    localparam int UNIT = 5;
    localparam int LW   = 16;
    localparam longint SATV = (longint'(1) << 34) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [7:0]    crm, cbm, prm, pbm;
    logic [4:0]    cre, cbe, pre, pbe;
    logic [3:0]    div;
    logic          pmode;
    logic [LW-1:0] off;
    logic [8:0]    adjm;
    logic [4:0]    adje;
    logic [1:0]    cmode, ag, ay, ar;
    logic          pkt_valid = 1'b0;
    logic          pkt_ready;
    logic [LW-1:0] pkt_len = '0;
    logic [1:0]    pkt_color = '0;
    logic          res_valid;
    logic [1:0]    res_color;
    logic          res_drop;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    longint m_lvl [2];
    longint m_cap [2];
    longint m_fill[2];

    trtcm_policer #(.UNIT_CYCLES(UNIT), .LEN_W(LW)) u0 (
        .clk(clk), .rst(rst),
        .cfg_crate_man(crm), .cfg_crate_exp(cre),
        .cfg_cburst_man(cbm), .cfg_cburst_exp(cbe),
        .cfg_prate_man(prm), .cfg_prate_exp(pre),
        .cfg_pburst_man(pbm), .cfg_pburst_exp(pbe),
        .cfg_tick_div(div), .cfg_pkt_mode(pmode), .cfg_len_off(off),
        .cfg_adj_man(adjm), .cfg_adj_exp(adje), .cfg_color_mode(cmode),
        .cfg_act_green(ag), .cfg_act_yellow(ay), .cfg_act_red(ar),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_len(pkt_len),
        .pkt_color(pkt_color), .res_valid(res_valid), .res_color(res_color),
        .res_drop(res_drop)
    );

    function automatic longint amt(int m, int e);
        if (e >= 24) return 0;
        return longint'(256 + m) << e;
    endfunction

    function automatic longint cost_of(int len);
        longint l, s;
        l = (pmode || len <= int'(off)) ? 0 : longint'(len) - longint'(off);
        s = l * 256 + (longint'(adjm) - 256) * (longint'(1) << adje);
        if (s < 1) s = 1;
        if (s > SATV) s = SATV;
        return s;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_base();
        crm = 0; cre = 24; cbm = 0; cbe = 4;
        prm = 0; pre = 24; pbm = 0; pbe = 24;
        div = 0; pmode = 0; off = 0; adjm = 9'd256; adje = 0;
        cmode = 2'd3; ag = 0; ay = 0; ar = 2'd1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b0;
        m_cap[0]  = amt(cbm, cbe); m_cap[1]  = amt(pbm, pbe);
        m_fill[0] = amt(crm, cre); m_fill[1] = amt(prm, pre);
        m_lvl[0]  = m_cap[0];      m_lvl[1]  = m_cap[1];
        chk(res_valid == 1'b0, "R1 res_valid after reset", res_valid, 0);
    endtask

    // one cycle: drive at a falling edge, predict, check at the next falling edge
    task automatic step(input bit v, input int len, input int col, input string tag,
                        output bit acc, output bit rdy);
        int ic, ecol;
        longint c;
        bit edrop, has;
        pkt_valid = v; pkt_len = LW'(len); pkt_color = 2'(col);
        rdy = pkt_ready;
        has = 1'b0; acc = 1'b0; ecol = 0; edrop = 1'b0;
        if (v && rdy) begin
            ic = (cmode == 2'd3) ? 0 : col;
            if (ic == 3) ic = 2;
            c = cost_of(len);
            if (ic == 0 && m_lvl[0] >= c) begin ecol = 0; m_lvl[0] -= c; end
            else if (ic <= 1 && m_lvl[1] >= c) begin ecol = 1; m_lvl[1] -= c; end
            else ecol = 2;
            edrop = ((ecol == 0) ? ag : (ecol == 1) ? ay : ar) != 2'd0;
            has = 1'b1; acc = 1'b1;
        end else if (!rdy) begin
            for (int b = 0; b < 2; b++) begin
                m_lvl[b] = m_lvl[b] + m_fill[b];
                if (m_lvl[b] > m_cap[b]) m_lvl[b] = m_cap[b];
            end
        end
        @(posedge clk); @(negedge clk);
        pkt_valid = 1'b0;
        if (has) begin
            chk(res_valid == 1'b1, {"R11 ", tag}, res_valid, 1);
            chk(int'(res_color) == ecol, {"R6 R7 color ", tag}, res_color, ecol);
            chk(res_drop == edrop, {"R10 drop ", tag}, res_drop, edrop);
        end else begin
            chk(res_valid == 1'b0, {"R11 idle ", tag}, res_valid, 0);
        end
    endtask

    task automatic send(input int len, input int col, input string tag);
        bit a, r;
        int n;
        n = 0;
        do begin
            step(1'b1, len, col, tag, a, r);
            n++;
        end while (!a && n < 4);
        chk(a, {"R2 accept ", tag}, a, 1);
    endtask

    task automatic idle(input int n, input string tag);
        bit a, r;
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, tag, a, r);
    endtask

    task automatic send_expect(input int len, input int col, input int ecol, input string tag);
        send(len, col, tag);
        chk(int'(res_color) == ecol, {"directed ", tag}, res_color, ecol);
    endtask

    task automatic measure_gap(input int gap, input string tag);
        int pos[3];
        int found;
        bit a, r;
        found = 0;
        for (int i = 0; i < gap * 4 + 4 && found < 3; i++) begin
            step(1'b0, 0, 0, tag, a, r);
            if (!r) begin pos[found] = i; found++; end
        end
        chk(found == 3, {"R2 ticks seen ", tag}, found, 3);
        if (found == 3) begin
            chk(pos[1] - pos[0] == gap, {"R2 gap ", tag}, pos[1] - pos[0], gap);
            chk(pos[2] - pos[1] == gap, {"R2 gap ", tag}, pos[2] - pos[1], gap);
        end
        // a packet offered in a refill cycle is held back
        for (int i = 0; i < gap + 2; i++) begin
            r = pkt_ready;
            if (!r) begin
                step(1'b1, 1, 0, "R2 blocked", a, r);
                chk(a == 1'b0, "R2 no accept on refill", a, 0);
                break;
            end
            step(1'b0, 0, 0, tag, a, r);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        set_base();
        @(negedge clk);

        // R1 R9: full bucket after reset, blind mode ignores a red tag
        do_reset();
        send_expect(16, 2, 0, "R1 R9 full cap fits exactly");
        send_expect(1, 0, 2, "R8 empty commit, unused peak");

        // R2 refill interval
        set_base(); div = 4'd2; do_reset();
        measure_gap(UNIT * 4, "div2");
        set_base(); div = 4'd0; do_reset();
        measure_gap(UNIT, "div0");

        // R3 refill amount and clamp
        set_base(); cbe = 3; crm = 8'd128; cre = 1; do_reset();
        send_expect(8, 0, 0, "R3 drain");
        idle(UNIT, "R3 one refill");
        send(4, 0, "R3 after one refill");
        idle(UNIT * 8, "R3 many refills");
        send_expect(9, 0, 2, "R3 clamped above cap");
        send_expect(8, 0, 0, "R3 clamped to cap");

        // R4 offset and negative adjust
        set_base(); off = 4; adjm = 9'd128; adje = 2; do_reset();
        send_expect(10, 0, 0, "R4 len minus offset");
        send(2, 0, "R4 minimum cost");
        send_expect(60, 0, 2, "R4 too large");
        adjm = 9'd511; adje = 5'd31;
        send_expect(0, 0, 2, "R4 saturated cost");

        // R5 packet mode: one token each
        set_base(); cbe = 2; pmode = 1; adjm = 9'd384; adje = 1; do_reset();
        for (int i = 0; i < 4; i++) send_expect(int'($urandom % 1000), 0, 0, "R5 one token");
        send_expect(3, 0, 2, "R5 budget spent");

        // R7 R10 yellow, reserved action codes drop
        set_base(); cbe = 2; pbe = 3; ay = 2'd2; ar = 2'd3; do_reset();
        send_expect(3, 0, 0, "R6 green");
        send_expect(3, 0, 1, "R7 yellow");
        send_expect(3, 0, 1, "R7 yellow again");
        send_expect(3, 0, 2, "R7 red");

        // R9 color aware
        set_base(); cbe = 2; pbe = 3; cmode = 2'd0; do_reset();
        send_expect(1, 2, 2, "R9 red stays red");
        send_expect(1, 3, 2, "R9 code 3 is red");
        send_expect(1, 1, 1, "R9 yellow uses peak");
        send_expect(1, 0, 0, "R9 green uses commit");

        // random traffic against the model
        for (int rnd = 0; rnd < 6; rnd++) begin
            crm = 8'($urandom); cre = 5'(2 + $urandom % 6);
            cbm = 8'($urandom); cbe = 5'(8 + $urandom % 5);
            if ($urandom % 3 == 0) begin
                prm = 0; pre = 24; pbm = 0; pbe = 24;
            end else begin
                prm = 8'($urandom); pre = 5'(2 + $urandom % 6);
                pbm = 8'($urandom); pbe = 5'(8 + $urandom % 5);
            end
            div = 4'($urandom % 3);
            pmode = ($urandom % 4 == 0);
            off = LW'($urandom % 8);
            adjm = pmode ? 9'd384 : 9'(200 + $urandom % 112);
            adje = pmode ? 5'd1 : 5'($urandom % 4);
            cmode = 2'($urandom); ag = 2'($urandom); ay = 2'($urandom); ar = 2'($urandom);
            do_reset();
            for (int i = 0; i < 500; i++) begin
                bit a, r;
                step(($urandom % 10) < 6, int'($urandom % 64), int'($urandom % 4),
                     "random", a, r);
            end
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule